// File: doc/BRIEF.md
# Channel Bit Error Tally

This block counts bit errors during a bit error rate test on one monitored timeslot of a serial input. The timeslot's bits arrive one at a time with a valid strobe, each paired with the bit the test pattern expects in that position. Once a full channel word of `CH_BITS` bits has arrived, the block compares it with the expected word. It then adds the number of differing bits to a live counter that the host cannot see. A received word of all ones is dropped and never counted.

A two-state controller governs the test. `ST_IDLE` moves to `ST_RUN` on a start pulse; this is the transition "arm". `ST_RUN` moves back to `ST_IDLE` on a stop pulse; this is the transition "halt". At halt the live count is copied into the host-readable count register, and the host cannot write that register. A rising edge on the clear level zeroes both counters and any partly received word. The clear edge takes no action on the state. Generating the pattern, choosing the stream and channel, and the host bus are outside this block.

Top module: `chan_err_tally`

## Requirements
- R1: After reset the controller is in `ST_IDLE` and `err_count` reads zero.
- R2: A start pulse in `ST_IDLE` enters `ST_RUN` ("arm"), zeroes the live counter and the partial word, and leaves `err_count` unchanged.
- R3: In `ST_RUN`, every `CH_BITS` strobed bits form one word, taken in arrival order. When the last bit of a word arrives, the live counter grows by the number of positions where `bit_in` differed from `exp_bit`. Bits strobed in `ST_IDLE` are ignored.
- R4: A received word whose bits are all 1 adds nothing to the live counter, whatever the expected bits are.
- R5: A stop pulse in `ST_RUN` ("halt") returns to `ST_IDLE` and loads `err_count` with the live count. A bit strobed in the same cycle as that stop is not counted.
- R6: A stop pulse in `ST_IDLE` has no effect. A start pulse in `ST_RUN` has no effect and does not zero the live count.
- R7: The live counter saturates at 2^`CNT_W`-1 and never wraps.
- R8: A 0-to-1 transition of `clear_lvl` zeroes `err_count`, the live counter and the partial word. Holding `clear_lvl` high has no further effect.
- R9: A clear edge in the same cycle as a halt leaves the block in `ST_IDLE` with `err_count` at zero.
- R10: `err_count` changes only on a halt or a clear edge. Arming and counting do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_pulse | input | 1 | One-cycle test start request |
| stop_pulse | input | 1 | One-cycle test stop request |
| clear_lvl | input | 1 | Clear control level; only its rising edge acts |
| bit_in | input | 1 | Received bit of the monitored channel |
| bit_valid | input | 1 | Strobe marking `bit_in` as a channel bit |
| exp_bit | input | 1 | Expected pattern bit for the same position |
| err_count | output | CNT_W | Host-readable error count register |

## Verification
The bench builds the block with `CH_BITS` = 8 and `CNT_W` = 10. A word then holds 0 to 8 errors, and the live counter saturates at 1023. Saturation is therefore reached in about 130 words of inverted data, a little over a thousand cycles. This lets one run cover saturation as well as randomised tests, all-ones words, clear edges held across a whole test, and stops that land on the last bit of a word.

// File: rtl/chan_ber_pkg.sv
package chan_ber_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ber_state_t;

endpackage

// File: rtl/ber_clr_edge.sv
module ber_clr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);

    logic lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= lvl;
        end
    end

    // Acts in the first cycle the level is seen high.
    assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/ber_word_cmp.sv
module ber_word_cmp #(
    parameter int CH_BITS = 8,
    localparam int POS_W  = (CH_BITS > 1) ? $clog2(CH_BITS) : 1,
    localparam int ERR_W  = $clog2(CH_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             enable,
    input  logic             bit_in,
    input  logic             bit_valid,
    input  logic             exp_bit,
    output logic             word_done,
    output logic [ERR_W-1:0] word_errs,
    output logic             word_ones
);

    logic [POS_W-1:0] pos_q;
    logic [ERR_W-1:0] errs_q;
    logic             ones_q;
    logic             take;
    logic             last;
    logic             bit_err;

    assign bit_err = bit_in ^ exp_bit;
    assign take    = enable & bit_valid;
    assign last    = take & (pos_q == POS_W'(CH_BITS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q  <= '0;
            errs_q <= '0;
            ones_q <= 1'b1;
        end else if (flush || last) begin
            pos_q  <= '0;
            errs_q <= '0;
            ones_q <= 1'b1;
        end else if (take) begin
            pos_q  <= pos_q + POS_W'(1);
            errs_q <= errs_q + ERR_W'(bit_err);
            ones_q <= ones_q & bit_in;
        end
    end

    // Totals include the bit completing the word.
    assign word_done = last;
    assign word_errs = errs_q + ERR_W'(bit_err);
    assign word_ones = ones_q & bit_in;

endmodule

// File: rtl/ber_sat_acc.sv
module ber_sat_acc #(
    parameter int CNT_W = 16,
    parameter int ADD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zero,
    input  logic             add_en,
    input  logic [ADD_W-1:0] add_val,
    output logic [CNT_W-1:0] acc
);

    localparam logic [CNT_W-1:0] MAXV = '1;

    logic [CNT_W:0] sum;

    assign sum = {1'b0, acc} + (CNT_W + 1)'(add_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (zero) begin
            acc <= '0;
        end else if (add_en) begin
            acc <= sum[CNT_W] ? MAXV : sum[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/chan_err_tally.sv
module chan_err_tally
    import chan_ber_pkg::*;
#(
    parameter int CH_BITS = 8,
    parameter int CNT_W   = 16,
    localparam int ERR_W  = $clog2(CH_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_pulse,
    input  logic             stop_pulse,
    input  logic             clear_lvl,
    input  logic             bit_in,
    input  logic             bit_valid,
    input  logic             exp_bit,
    output logic [CNT_W-1:0] err_count
);

    ber_state_t       st_q;
    ber_state_t       st_d;
    logic             clr_rise;
    logic             arm;
    logic             halt;
    logic             word_done;
    logic [ERR_W-1:0] word_errs;
    logic             word_ones;
    logic [CNT_W-1:0] live_cnt;

    ber_clr_edge u_clr (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (clear_lvl),
        .rise  (clr_rise)
    );

    assign arm  = (st_q == ST_IDLE) & start_pulse;
    assign halt = (st_q == ST_RUN) & stop_pulse;

    ber_word_cmp #(.CH_BITS(CH_BITS)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (clr_rise | arm),
        .enable    ((st_q == ST_RUN) & ~stop_pulse),
        .bit_in    (bit_in),
        .bit_valid (bit_valid),
        .exp_bit   (exp_bit),
        .word_done (word_done),
        .word_errs (word_errs),
        .word_ones (word_ones)
    );

    ber_sat_acc #(.CNT_W(CNT_W), .ADD_W(ERR_W)) u_live (
        .clk     (clk),
        .rst_n   (rst_n),
        .zero    (clr_rise | arm),
        .add_en  (word_done & ~word_ones),
        .add_val (word_errs),
        .acc     (live_cnt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions: arm (IDLE->RUN), halt (RUN->IDLE)
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start_pulse) st_d = ST_RUN;
            ST_RUN:  if (stop_pulse)  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // Output register: clear edge outranks the halt transfer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_count <= '0;
        end else if (clr_rise) begin
            err_count <= '0;
        end else if (halt) begin
            err_count <= live_cnt;
        end
    end

endmodule

// File: rtl/chan_err_tally_chk.sv
module chan_err_tally_chk
    import chan_ber_pkg::*;
#(
    parameter int CH_BITS = 8,
    parameter int CNT_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_pulse,
    input logic             stop_pulse,
    input ber_state_t       st_q,
    input logic             clr_rise,
    input logic             word_done,
    input logic             word_ones,
    input logic [CNT_W-1:0] live_cnt,
    input logic [CNT_W-1:0] err_count
);

    localparam logic [CNT_W-1:0] MAXV = '1;

    // R2
    p_arm_keeps_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && start_pulse && !clr_rise)
        |=> (st_q == ST_RUN && live_cnt == '0 && $stable(err_count)));

    // R3
    p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && !clr_rise)
        |=> ({1'b0, live_cnt} <= {1'b0, $past(live_cnt)} + (CNT_W + 1)'(CH_BITS)));

    // R4
    p_ones_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && !stop_pulse && !clr_rise && word_done && word_ones)
        |=> $stable(live_cnt));

    // R5
    p_halt_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && stop_pulse && !clr_rise)
        |=> (st_q == ST_IDLE && err_count == $past(live_cnt)));

    // R6
    p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !start_pulse) |=> (st_q == ST_IDLE));

    // R7
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt == MAXV && !clr_rise && !(st_q == ST_IDLE && start_pulse))
        |=> (live_cnt == MAXV));

    // R8
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rise |=> (err_count == '0 && live_cnt == '0));

    // R9
    p_clear_beats_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rise && stop_pulse && st_q == ST_RUN)
        |=> (st_q == ST_IDLE && err_count == '0));

    // R10
    p_reg_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_rise && !(st_q == ST_RUN && stop_pulse)) |=> $stable(err_count));

endmodule

bind chan_err_tally chan_err_tally_chk #(
    .CH_BITS (CH_BITS),
    .CNT_W   (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse),
    .st_q        (st_q),
    .clr_rise    (clr_rise),
    .word_done   (word_done),
    .word_ones   (word_ones),
    .live_cnt    (live_cnt),
    .err_count   (err_count)
);

// File: tb/chan_err_tally_tb.sv
`timescale 1ns/1ps
module chan_err_tally_tb;

    localparam int CH_BITS = 8;
    localparam int CNT_W   = 10;
    localparam int MAXV    = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_pulse = 1'b0;
    logic             stop_pulse = 1'b0;
    logic             clear_lvl = 1'b0;
    logic             bit_in = 1'b0;
    logic             bit_valid = 1'b0;
    logic             exp_bit = 1'b0;
    logic [CNT_W-1:0] err_count;

    int checks = 0;
    int errors = 0;
    int m_live = 0;
    int m_reg = 0;
    bit m_run = 1'b0;
    bit m_clr = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    chan_err_tally #(.CH_BITS(CH_BITS), .CNT_W(CNT_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse),
        .clear_lvl   (clear_lvl),
        .bit_in      (bit_in),
        .bit_valid   (bit_valid),
        .exp_bit     (exp_bit),
        .err_count   (err_count)
    );

    function automatic int word_errs(logic [7:0] rx, logic [7:0] ex);
        if (rx == 8'hFF) return 0;
        return $countones(rx ^ ex);
    endfunction

    function automatic int sat_add(int a, int b);
        return (a + b > MAXV) ? MAXV : a + b;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_bit(logic b, logic e, logic stp);
        bit_in = b; exp_bit = e; bit_valid = 1'b1; stop_pulse = stp;
        @(negedge clk);
        bit_valid = 1'b0; stop_pulse = 1'b0;
    endtask

    task automatic send_word(logic [7:0] rx, logic [7:0] ex, bit gaps);
        for (int i = 0; i < CH_BITS; i++) begin
            if (gaps && ($urandom % 3 == 0)) @(negedge clk);
            send_bit(rx[i], ex[i], 1'b0);
        end
        if (m_run) m_live = sat_add(m_live, word_errs(rx, ex));
    endtask

    task automatic do_start();
        start_pulse = 1'b1;
        @(negedge clk);
        start_pulse = 1'b0;
        if (!m_run) begin m_run = 1'b1; m_live = 0; end
    endtask

    task automatic do_stop();
        stop_pulse = 1'b1;
        @(negedge clk);
        stop_pulse = 1'b0;
        if (m_run) begin m_run = 1'b0; m_reg = m_live; end
    endtask

    task automatic set_clear(bit v);
        clear_lvl = v;
        @(negedge clk);
        if (v && !m_clr) begin m_live = 0; m_reg = 0; end
        m_clr = v;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        logic [7:0] ex;
        void'($urandom(32'd9917));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset count", int'(err_count), 0);

        // R2 R3 R5: basic test
        do_start();
        send_word(8'h00, 8'h0F, 1'b0);
        send_word(8'hA5, 8'h5A, 1'b1);
        send_word(8'h3C, 8'h3C, 1'b1);
        check("R10 count held while running", int'(err_count), 0);
        do_stop();
        check("R3 R5 halt transfer", int'(err_count), m_reg);

        // R4: all-ones words never count
        do_start();
        for (int k = 0; k < 6; k++) send_word(8'hFF, 8'($urandom), 1'b1);
        check("R2 arm leaves register", int'(err_count), 12);
        do_stop();
        check("R4 all-ones ignored", int'(err_count), 0);

        // R6: stop in idle, start while running
        do_start();
        send_word(8'h0F, 8'hF0, 1'b0);
        do_stop();
        do_stop();
        check("R6 stop in idle", int'(err_count), 8);
        do_start();
        send_word(8'h01, 8'h00, 1'b0);
        do_start();
        send_word(8'h03, 8'h00, 1'b0);
        do_stop();
        check("R6 start while running", int'(err_count), 3);

        // R3: bits while idle ignored, R5: bit in stop cycle ignored
        send_word(8'h00, 8'hFF, 1'b0);
        check("R3 idle bits ignored", int'(err_count), 3);
        do_start();
        send_word(8'h07, 8'h00, 1'b0);
        for (int i = 0; i < CH_BITS - 1; i++) send_bit(1'b0, 1'b1, 1'b0);
        send_bit(1'b0, 1'b1, 1'b1);
        m_run = 1'b0; m_reg = m_live;
        check("R5 stop-cycle bit dropped", int'(err_count), 3);

        // R8: clear edge, held level, partial word
        set_clear(1'b1);
        check("R8 clear edge zeroes", int'(err_count), 0);
        do_start();
        send_word(8'h00, 8'h1F, 1'b1);
        do_stop();
        check("R8 held clear no effect", int'(err_count), 5);
        set_clear(1'b0);
        do_start();
        send_bit(1'b1, 1'b0, 1'b0);
        send_bit(1'b1, 1'b0, 1'b0);
        send_bit(1'b1, 1'b0, 1'b0);
        set_clear(1'b1);
        check("R8 clear while running", int'(err_count), 0);
        send_word(8'h00, 8'h03, 1'b0);
        do_stop();
        check("R8 partial word flushed", int'(err_count), 2);
        set_clear(1'b0);

        // R9: clear edge with halt
        do_start();
        send_word(8'h00, 8'hFF, 1'b0);
        clear_lvl = 1'b1; stop_pulse = 1'b1;
        @(negedge clk);
        stop_pulse = 1'b0;
        m_run = 1'b0; m_live = 0; m_reg = 0; m_clr = 1'b1;
        check("R9 clear beats halt", int'(err_count), 0);
        do_stop();
        check("R9 left idle", int'(err_count), 0);
        set_clear(1'b0);

        // R7: saturation
        do_start();
        for (int k = 0; k < 140; k++) send_word(8'h00, 8'hFF, 1'b0);
        do_stop();
        check("R7 saturates", int'(err_count), MAXV);

        // Random tests
        for (int t = 0; t < 12; t++) begin
            int n;
            do_start();
            check("R10 arm keeps register", int'(err_count), m_reg);
            n = 1 + ($urandom % 6);
            for (int k = 0; k < n; k++) begin
                rx = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom);
                ex = 8'($urandom);
                send_word(rx, ex, 1'b1);
            end
            do_stop();
            check("R3 random test", int'(err_count), m_reg);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule